// File: doc/BRIEF.md
# Accumulator ALU with Flags

This unit is the arithmetic and logic datapath of an 8-bit accumulator machine. Each operation is issued with a start strobe, a 4-bit operation code, the current accumulator byte, one second operand byte and the current carry flag. The second operand is register B for multiply, the addressed byte for the digit exchange, and any register, memory or immediate byte for the rest. Fetch and addressing happen upstream, so the operand byte arrives ready. The unit returns a new accumulator value, a write-back value for the operand byte, and new carry, auxiliary-carry and overflow flags. Each of these outputs has its own write-enable. A value output reads zero whenever its enable is low.

Every operation except multiply produces its result combinationally in the cycle it is issued. Multiply is an unsigned 8x8 multiply built as a shift-and-add sequence. It occupies four cycles: busy is high in the issue cycle and in the two cycles after it, and the product and flags are presented in the fourth cycle. While a multiply is running, new starts are ignored.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 multiplies the accumulator and the operand as unsigned bytes. The low byte of the product is written to the accumulator and the high byte to the operand output. Both enables are high in the third cycle after the issue cycle, and never earlier.
- R2: When operation code 0 completes, overflow is written as 1 exactly when the product exceeds 0xFF. Carry is written as 0. Auxiliary carry is not written. For example, 0x50 times 0xA0 gives operand 0x32, accumulator 0x00 and overflow 1.
- R3: After a multiply is issued, busy is high in the issue cycle and the two following cycles, and low in the result cycle. No write-enable is high while busy is high.
- R4: A start presented in any of the three cycles after a multiply issue is ignored: no output reflects it, and no operation starts because of it.
- R5: Operation code 1 writes A − operand − carry (mod 256) to the accumulator. Carry is written as 1 when bit 7 needs a borrow.
- R6: For operation code 1, auxiliary carry is written as 1 when bit 3 needs a borrow. Overflow is written as the XOR of the borrow out of bit 6 and the borrow out of bit 7. For example, 0xC9 − 0x54 with carry 1 gives 0x74 with carry 0, auxiliary carry 0 and overflow 1.
- R7: Codes 2 (rotate left, bit 7 into bit 0) and 4 (rotate right, bit 0 into bit 7) write only the accumulator.
- R8: Codes 3 and 5 rotate the 9-bit value formed by carry and the accumulator. For code 3, bit 7 goes into carry and the old carry into bit 0. Code 5 mirrors this. Both write the accumulator and carry only.
- R9: Code 6 swaps the two nibbles of the accumulator (0xC5 becomes 0x5C) and writes no flag.
- R10: Code 7 exchanges the low nibbles of the accumulator and the operand and keeps both high nibbles. 0x36 with 0x75 gives accumulator 0x35 and operand 0x76. No flag is written.
- R11: Code 8 writes accumulator OR operand, and code 9 writes accumulator XOR operand. Neither writes a flag.
- R12: Codes 10 to 15, and any cycle without an accepted start, raise no write-enable. Busy stays low unless a multiply is running.
- R13: Synchronous active-low reset abandons a running multiply. The cycle after reset is released shows busy low and all enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue strobe for the operation on `op` |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand byte |
| cy_in | input | 1 | Current carry flag |
| busy | output | 1 | Multiply in progress, result not yet valid |
| acc_we | output | 1 | Accumulator write-enable |
| acc_out | output | 8 | New accumulator value |
| opnd_we | output | 1 | Operand write-back enable |
| opnd_out | output | 8 | Operand write-back value |
| cy_we | output | 1 | Carry write-enable |
| cy_out | output | 1 | New carry |
| ac_we | output | 1 | Auxiliary-carry write-enable |
| ac_out | output | 1 | New auxiliary carry |
| ov_we | output | 1 | Overflow write-enable |
| ov_out | output | 1 | New overflow |

## Verification
Multiply is exercised with products on each side of the 0xFF overflow threshold (0xFF, 0x100 and 0xFE01), and with back-to-back issues. Another run holds start high through the busy window, so that an ignored start can be told apart from an accepted one. Subtract is driven with and without incoming borrow, including the 0 − 0 − 1 wrap and a sign flip at 0x80. This separates the bit-3, bit-6 and bit-7 borrows from one another. The rotates are run with both carry values, which shows whether carry enters the result and whether the plain rotates leave it alone. A long stream of random codes and operands then mixes every operation with unused codes and idle cycles.

// File: rtl/acc_alu_pkg.sv
// Package: operation codes and the flag-update bundle shared by the ALU parts.
// Assumes: codes 10..15 are unused and must produce no writes.
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_MUL  = 4'd0,
        OP_SUBB = 4'd1,
        OP_RL   = 4'd2,
        OP_RLC  = 4'd3,
        OP_RR   = 4'd4,
        OP_RRC  = 4'd5,
        OP_SWAP = 4'd6,
        OP_XCHD = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9
    } acc_op_e;

    typedef struct packed {
        logic cy_we;
        logic cy;
        logic ac_we;
        logic ac;
        logic ov_we;
        logic ov;
    } flag_upd_t;

endpackage

// File: rtl/acc_alu_logic.sv
// Module: single-cycle operations (subtract with borrow, rotates, swap,
// digit exchange, OR, XOR). Purely combinational.
// Assumes: the caller gates 'valid' so that enables rise only on accepted issues.
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          valid,
    input  acc_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c,
    output logic          acc_we,
    output logic [DW-1:0] acc_o,
    output logic          opnd_we,
    output logic [DW-1:0] opnd_o,
    output flag_upd_t     flags
);
    localparam int unsigned NIB = DW / 2;

    logic [DW:0]    diff_full;
    logic [NIB:0]   diff_nib;
    logic [DW-1:0]  diff_low;

    // Borrow chains: full width, low nibble, all bits below the top one.
    always_comb begin
        diff_full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, c};
        diff_nib  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, c};
        diff_low  = {1'b0, a[DW-2:0]} - {1'b0, b[DW-2:0]} - {{(DW-1){1'b0}}, c};
    end

    // Per-operation result and enable selection.
    always_comb begin
        acc_we  = 1'b0;
        acc_o   = '0;
        opnd_we = 1'b0;
        opnd_o  = '0;
        flags   = '0;
        if (valid) begin
            case (op)
                OP_SUBB: begin
                    acc_we      = 1'b1;
                    acc_o       = diff_full[DW-1:0];
                    flags.cy_we = 1'b1;
                    flags.cy    = diff_full[DW];
                    flags.ac_we = 1'b1;
                    flags.ac    = diff_nib[NIB];
                    flags.ov_we = 1'b1;
                    flags.ov    = diff_full[DW] ^ diff_low[DW-1];
                end
                OP_RL: begin
                    acc_we = 1'b1;
                    acc_o  = {a[DW-2:0], a[DW-1]};
                end
                OP_RLC: begin
                    acc_we      = 1'b1;
                    acc_o       = {a[DW-2:0], c};
                    flags.cy_we = 1'b1;
                    flags.cy    = a[DW-1];
                end
                OP_RR: begin
                    acc_we = 1'b1;
                    acc_o  = {a[0], a[DW-1:1]};
                end
                OP_RRC: begin
                    acc_we      = 1'b1;
                    acc_o       = {c, a[DW-1:1]};
                    flags.cy_we = 1'b1;
                    flags.cy    = a[0];
                end
                OP_SWAP: begin
                    acc_we = 1'b1;
                    acc_o  = {a[NIB-1:0], a[DW-1:NIB]};
                end
                OP_XCHD: begin
                    acc_we  = 1'b1;
                    acc_o   = {a[DW-1:NIB], b[NIB-1:0]};
                    opnd_we = 1'b1;
                    opnd_o  = {b[DW-1:NIB], a[NIB-1:0]};
                end
                OP_OR: begin
                    acc_we = 1'b1;
                    acc_o  = a | b;
                end
                OP_XOR: begin
                    acc_we = 1'b1;
                    acc_o  = a ^ b;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/acc_alu_mul.sv
// Module: multi-cycle unsigned multiplier built from shift-and-add steps.
// The issue edge performs the first step. MUL_CYCLES-1 steps of BPS bits
// each cover the multiplier. The final cycle presents the product.
// Assumes: 'go' is raised only while 'idle' is high; MUL_CYCLES >= 2.
module acc_alu_mul #(
    parameter int unsigned DW         = 8,
    parameter int unsigned MUL_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic            idle,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] prod
);
    localparam int unsigned STEPS = MUL_CYCLES - 1;
    localparam int unsigned BPS   = (DW + STEPS - 1) / STEPS;
    localparam int unsigned BW    = STEPS * BPS;
    localparam int unsigned PW    = $clog2(MUL_CYCLES);
    localparam logic [PW-1:0] LAST = PW'(STEPS);

    logic [PW-1:0]   ph_r;
    logic [2*DW-1:0] a_sh_r;
    logic [BW-1:0]   b_sh_r;
    logic [2*DW-1:0] prod_r;
    logic [2*DW-1:0] cur_a;
    logic [BW-1:0]   cur_b;
    logic [2*DW-1:0] pp_term [BPS];
    logic [2*DW-1:0] pp_sum;
    logic            step;

    // Sequencer status decoded from the phase counter.
    assign idle = (ph_r == '0);
    assign done = (ph_r == LAST);
    assign busy = go || (!idle && !done);
    assign step = go || (!idle && !done);
    assign prod = prod_r;

    // Operand selection: live inputs on the issue step, shifted copies afterwards.
    assign cur_a = idle ? {{DW{1'b0}}, a} : a_sh_r;
    assign cur_b = idle ? {{(BW-DW){1'b0}}, b} : b_sh_r;

    // One gated partial product per multiplier bit of the current step.
    for (genvar i = 0; i < BPS; i++) begin : g_pp
        assign pp_term[i] = cur_b[i] ? (cur_a << i) : '0;
    end

    // Sum of this step's partial products.
    always_comb begin
        pp_sum = '0;
        for (int i = 0; i < BPS; i++) pp_sum = pp_sum + pp_term[i];
    end

    // Phase counter and shift-add state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_r   <= '0;
            a_sh_r <= '0;
            b_sh_r <= '0;
            prod_r <= '0;
        end else if (step) begin
            ph_r   <= ph_r + 1'b1;
            a_sh_r <= cur_a << BPS;
            b_sh_r <= cur_b >> BPS;
            prod_r <= (idle ? '0 : prod_r) + pp_sum;
        end else if (done) begin
            ph_r <= '0;
        end
    end

endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU top. Accepts an issue only while the multiplier is
// idle. It routes a finished product or a single-cycle result to the outputs,
// and drives every value output to zero while its enable is low.
// Assumes: the operand byte is already fetched when start is high.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int unsigned DW         = 8,
    parameter int unsigned MUL_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic          cy_in,
    output logic          busy,
    output logic          acc_we,
    output logic [DW-1:0] acc_out,
    output logic          opnd_we,
    output logic [DW-1:0] opnd_out,
    output logic          cy_we,
    output logic          cy_out,
    output logic          ac_we,
    output logic          ac_out,
    output logic          ov_we,
    output logic          ov_out
);
    acc_op_e         op_e;
    logic            mul_idle;
    logic            mul_busy;
    logic            mul_done;
    logic            accept;
    logic            mul_go;
    logic [2*DW-1:0] mul_prod;
    logic            lg_acc_we;
    logic [DW-1:0]   lg_acc;
    logic            lg_opnd_we;
    logic [DW-1:0]   lg_opnd;
    flag_upd_t       lg_flags;

    // Issue acceptance: only when no multiply holds the unit.
    assign op_e   = acc_op_e'(op);
    assign accept = start && mul_idle;
    assign mul_go = accept && (op_e == OP_MUL);

    acc_alu_mul #(.DW(DW), .MUL_CYCLES(MUL_CYCLES)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .a     (acc_in),
        .b     (opnd_in),
        .idle  (mul_idle),
        .busy  (mul_busy),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    acc_alu_logic #(.DW(DW)) u_logic (
        .valid   (accept && !mul_go),
        .op      (op_e),
        .a       (acc_in),
        .b       (opnd_in),
        .c       (cy_in),
        .acc_we  (lg_acc_we),
        .acc_o   (lg_acc),
        .opnd_we (lg_opnd_we),
        .opnd_o  (lg_opnd),
        .flags   (lg_flags)
    );

    assign busy = mul_busy;

    // Output routing: finished product, otherwise single-cycle result.
    always_comb begin
        if (mul_done) begin
            acc_we   = 1'b1;
            acc_out  = mul_prod[DW-1:0];
            opnd_we  = 1'b1;
            opnd_out = mul_prod[2*DW-1:DW];
            cy_we    = 1'b1;
            cy_out   = 1'b0;
            ac_we    = 1'b0;
            ac_out   = 1'b0;
            ov_we    = 1'b1;
            ov_out   = |mul_prod[2*DW-1:DW];
        end else begin
            acc_we   = lg_acc_we;
            acc_out  = lg_acc;
            opnd_we  = lg_opnd_we;
            opnd_out = lg_opnd;
            cy_we    = lg_flags.cy_we;
            cy_out   = lg_flags.cy;
            ac_we    = lg_flags.ac_we;
            ac_out   = lg_flags.ac;
            ov_we    = lg_flags.ov_we;
            ov_out   = lg_flags.ov;
        end
    end

endmodule

// File: rtl/acc_alu_chk.sv
// Module: protocol and flag checker for acc_alu, attached through bind.
// Assumes: port names of acc_alu; observes only, drives nothing.
module acc_alu_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    op,
    input logic [DW-1:0] acc_in,
    input logic [DW-1:0] opnd_in,
    input logic          busy,
    input logic          acc_we,
    input logic [DW-1:0] acc_out,
    input logic          opnd_we,
    input logic [DW-1:0] opnd_out,
    input logic          cy_we,
    input logic          cy_out,
    input logic          ac_we,
    input logic          ov_we,
    input logic          ov_out
);
    // R3: nothing is written while busy.
    assert_quiet_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(acc_we || opnd_we || cy_we || ac_we || ov_we));

    // R3: a busy cycle is followed by more busy or by the product.
    assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || (acc_we && opnd_we && ov_we)));

    // R1: the falling edge of busy carries the product writes.
    assert_result_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> (acc_we && opnd_we));

    // R2: multiply result flags.
    assert_mul_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_we && ov_we) |-> (cy_we && !cy_out && !ac_we && (ov_out == (opnd_out != '0))));

    // R11: OR/XOR write only the accumulator.
    assert_logic_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !ov_we && (op == 4'd8 || op == 4'd9))
            |-> (acc_we && !cy_we && !ac_we && !opnd_we
                 && acc_out == ((op == 4'd8) ? (acc_in | opnd_in) : (acc_in ^ opnd_in))));

    // R12: unused codes write nothing.
    assert_unused_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ov_we && op >= 4'd10) |-> !(acc_we || opnd_we || cy_we || ac_we));

endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .acc_in   (acc_in),
    .opnd_in  (opnd_in),
    .busy     (busy),
    .acc_we   (acc_we),
    .acc_out  (acc_out),
    .opnd_we  (opnd_we),
    .opnd_out (opnd_out),
    .cy_we    (cy_we),
    .cy_out   (cy_out),
    .ac_we    (ac_we),
    .ov_we    (ov_we),
    .ov_out   (ov_out)
);

// File: tb/acc_alu_tb.sv
// Bench: behavioural reference model compared against the outputs every cycle.
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] opnd_in = 8'd0;
    logic       cy_in = 1'b0;
    logic       busy, acc_we, opnd_we, cy_we, cy_out, ac_we, ac_out, ov_we, ov_out;
    logic [7:0] acc_out, opnd_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int mphase = 0;
    int mprod = 0;

    always #2.5 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_in(acc_in),
        .opnd_in(opnd_in), .cy_in(cy_in), .busy(busy), .acc_we(acc_we),
        .acc_out(acc_out), .opnd_we(opnd_we), .opnd_out(opnd_out),
        .cy_we(cy_we), .cy_out(cy_out), .ac_we(ac_we), .ac_out(ac_out),
        .ov_we(ov_we), .ov_out(ov_out)
    );

    // Reference: result bundle {acc_we,acc,opnd_we,opnd,cy_we,cy,ac_we,ac,ov_we,ov}
    function automatic logic [23:0] ref_single(int o, int a, int b, int c);
        int r = 0, ob = 0, d;
        logic aw = 1, owe = 0, cw = 0, cv = 0, acw = 0, acv = 0, ow = 0, ov = 0;
        case (o)
            1: begin
                d = a - b - c; r = d & 255; cw = 1; cv = (d < 0);
                acw = 1; acv = (((a & 15) - (b & 15) - c) < 0);
                ow = 1; ov = ((((a & 127) - (b & 127) - c) < 0) != (d < 0));
            end
            2: r = ((a << 1) | (a >> 7)) & 255;
            3: begin r = ((a << 1) | c) & 255; cw = 1; cv = a[7]; end
            4: r = (a >> 1) | ((a & 1) << 7);
            5: begin r = (a >> 1) | (c << 7); cw = 1; cv = a[0]; end
            6: r = ((a & 15) << 4) | (a >> 4);
            7: begin r = (a & 240) | (b & 15); owe = 1; ob = (b & 240) | (a & 15); end
            8: r = a | b;
            9: r = a ^ b;
            default: aw = 0;
        endcase
        return {aw, 8'(r), owe, 8'(ob), cw, cv, acw, acv, ow, ov};
    endfunction

    // Reference sequencer for multiply, advanced on each clock edge.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) mphase <= 0;
        else if (mphase == 0 && start && op == 4'd0) begin
            mphase <= 1; mprod <= int'(acc_in) * int'(opnd_in);
        end else if (mphase != 0) mphase <= (mphase == 3) ? 0 : mphase + 1;
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        logic [24:0] exp_v, act_v;
        string tag;
        #1;
        act_v = {busy, acc_we, acc_out, opnd_we, opnd_out, cy_we, cy_out,
                 ac_we, ac_out, ov_we, ov_out};
        if (mphase == 3) begin
            exp_v = {1'b0, 1'b1, 8'(mprod), 1'b1, 8'(mprod >> 8), 1'b1, 1'b0,
                     1'b0, 1'b0, 1'b1, 1'(mprod > 255)};
            tag = start ? "R4 R1 R2" : "R1 R2";
        end else if (mphase != 0) begin
            exp_v = {1'b1, 24'd0};
            tag = start ? "R4" : "R3";
        end else if (start && op == 4'd0) begin
            exp_v = {1'b1, 24'd0}; tag = "R3";
        end else if (start) begin
            exp_v = {1'b0, ref_single(int'(op), int'(acc_in), int'(opnd_in), int'(cy_in))};
            case (op)
                4'd1: tag = "R5 R6";
                4'd2, 4'd4: tag = "R7";
                4'd3, 4'd5: tag = "R8";
                4'd6: tag = "R9";
                4'd7: tag = "R10";
                4'd8, 4'd9: tag = "R11";
                default: tag = "R12";
            endcase
        end else begin
            exp_v = 25'd0; tag = "R12";
        end
        if (!rst_n || !$past(rst_n)) tag = {tag, " R13"};
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s op=%0d actual=%h expected=%h", tag, op, act_v, exp_v);
        end
    end

    task automatic issue(input int o, input int a, input int b, input int c);
        @(negedge clk);
        start = 1'b1; op = 4'(o); acc_in = 8'(a); opnd_in = 8'(b); cy_in = 1'(c);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic mul(input int a, input int b);
        issue(0, a, b, 0);
        idle(3);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);                                  // R13 reset state
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        mul(8'h50, 8'hA0);                        // R1 R2 example
        mul(8'h0F, 8'h11);                        // R2 product 0xFF, no overflow
        mul(8'h10, 8'h10);                        // R2 product 0x100
        mul(8'hFF, 8'hFF);                        // R1 0xFE01
        issue(0, 8'h07, 8'h09, 1); issue(0, 8'h03, 8'h03, 0);  // R4 back-to-back
        issue(1, 8'h11, 8'h01, 0); issue(1, 8'h22, 8'h02, 0);  // R4 ignored starts
        issue(0, 8'h02, 8'h03, 0); idle(3);       // R1 issue right after result
        issue(1, 8'hC9, 8'h54, 1);                // R5 R6 example
        issue(1, 8'h00, 8'h00, 1);                // R5 R6 wrap
        issue(1, 8'h80, 8'h01, 0);                // R6 sign flip
        issue(2, 8'hC5, 0, 1); issue(4, 8'hC5, 0, 1);   // R7
        issue(3, 8'hC5, 0, 0); issue(3, 8'h45, 0, 1);   // R8
        issue(5, 8'hC5, 0, 0); issue(5, 8'hC4, 0, 1);   // R8
        issue(6, 8'hC5, 0, 0);                    // R9
        issue(7, 8'h36, 8'h75, 1);                // R10
        issue(8, 8'hC3, 8'h55, 0); issue(9, 8'hC3, 8'hAA, 1);  // R11
        issue(12, 8'hFF, 8'hFF, 1); issue(15, 8'h01, 8'h02, 0); // R12
        idle(2);
        issue(0, 8'h33, 8'h44, 0); idle(1);       // R13 reset mid-multiply
        @(negedge clk); rst_n = 1'b0;
        idle(1);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        for (int k = 0; k < 400; k++) begin
            int o = $urandom_range(0, 15);
            if ($urandom_range(0, 4) == 0) idle(1);
            else if (o == 0) mul($urandom_range(0, 255), $urandom_range(0, 255));
            else issue(o, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1));
        end
        idle(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule